// File: doc/BRIEF.md
# Flag-Aware Register Rename Table

This block is the register alias table of a small out-of-order core. Each physical register holds an integer result together with the six arithmetic flags produced by the same operation. The flags therefore have no storage of their own. The table has two extra slots, one for each flag group: group 0 is carry, and group 1 is the other five flags. Each extra slot names the physical register that last wrote that group. An instruction that writes only some of the flags moves only the matching slots. A later flag reader may find its groups held in two different physical registers, and it never depends on a flag value that was overwritten.

Each cycle the rename port accepts one instruction. In the same cycle it returns the physical tags of both integer sources and of both flag-group providers. When the instruction writes an integer destination, any flag group, or both, the port takes one free physical tag and records it in every slot the instruction writes. The commit port keeps a separate committed copy of all the slots. A flush loads the committed copy into the speculative table in one cycle. The free list is not stored. It is derived as every tag that no speculative slot and no committed slot refers to, and that no renamed but uncommitted instruction holds. A flush clears the uncommitted holds, which rebuilds the free list from the committed references.

Top module: `flag_rename_table`

## Requirements
- R1: After reset, architectural register i maps to physical tag i in both tables, both flag-group slots name physical tag 8, and tags 9 to 31 are free.
- R2: In the cycle an instruction is presented, ren_tag_a and ren_tag_b return the speculative mappings of ren_src_a and ren_src_b. ren_flag_tags returns the carry-group provider in bits [4:0] and the other-flags provider in bits [9:5].
- R3: An accepted rename that writes a destination maps that register to ren_new_tag from the next cycle on.
- R4: ren_flag_wr bit 0 selects the carry group and bit 1 selects the other-flags group. A rename moves only the selected groups' provider slots to the new tag; an unselected group keeps its provider.
- R5: A rename that writes both a destination and flags allocates exactly one tag, and that tag is used for the integer slot and for every written flag slot.
- R6: A rename with no destination and a zero flag mask allocates nothing: ren_alloc stays low and no tag is consumed.
- R7: When an allocation is needed and no tag is free, ren_stall is high, ren_alloc is low, and the speculative table is left unchanged.
- R8: The allocated tag is the lowest-numbered tag that no slot in either table refers to and that no uncommitted instruction holds. A tag returns to the pool only once all of these are false.
- R9: A commit writes its tag into the committed slots selected by cmt_dst_valid, cmt_dst and cmt_flag_wr, and releases that tag's uncommitted hold. A flush copies the committed table, flag slots included, into the speculative table in one cycle.
- R10: A flush releases every uncommitted hold, so tags that only wrong-path instructions held become allocatable again.
- R11: A rename presented in the same cycle as a flush is discarded: no allocation and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request present |
| ren_src_a | input | 3 | First architectural source |
| ren_src_b | input | 3 | Second architectural source |
| ren_dst_valid | input | 1 | Instruction writes an integer destination |
| ren_dst | input | 3 | Architectural destination |
| ren_flag_wr | input | 2 | Flag groups written (bit 0 carry, bit 1 other flags) |
| ren_tag_a | output | 5 | Physical tag of the first source |
| ren_tag_b | output | 5 | Physical tag of the second source |
| ren_flag_tags | output | 10 | Flag providers: [4:0] carry, [9:5] other flags |
| ren_alloc | output | 1 | A new tag was taken this cycle |
| ren_new_tag | output | 5 | Newly allocated physical tag |
| ren_stall | output | 1 | Allocation needed but pool empty |
| cmt_valid | input | 1 | Commit of the oldest instruction |
| cmt_dst_valid | input | 1 | Committing instruction writes a destination |
| cmt_dst | input | 3 | Its architectural destination |
| cmt_flag_wr | input | 2 | Its flag-group mask |
| cmt_tag | input | 5 | Its physical tag |
| flush | input | 1 | Restore speculative table from committed |

## Verification
All rename outputs are combinational lookups of the current table, so they are due in the same cycle the request is driven. Table writes, commit effects and flush restores become visible in the cycle after the clock edge that captures them. The driver applies each request one nanosecond after a rising edge and pushes the expected lookup into a queue. The monitor pops the queue and compares at the following falling edge. Every request is therefore checked within its own cycle, against a model that has absorbed all earlier edges.

// File: rtl/rat_pkg.sv
package rat_pkg;
    localparam int ARCH_REGS   = 8;
    localparam int PHYS_REGS   = 32;
    localparam int FLAG_GROUPS = 2;
    localparam int SLOTS       = ARCH_REGS + FLAG_GROUPS;
    localparam int TAG_W       = $clog2(PHYS_REGS);
    localparam int ARCH_W      = $clog2(ARCH_REGS);
    localparam int RESET_FLAG_TAG = ARCH_REGS;

    typedef logic [TAG_W-1:0]             tag_t;
    typedef logic [ARCH_W-1:0]            areg_t;
    typedef logic [FLAG_GROUPS-1:0]       fmask_t;
    typedef logic [SLOTS-1:0][TAG_W-1:0]  map_t;
    typedef logic [PHYS_REGS-1:0]         pvec_t;

    typedef struct packed {
        logic   valid;
        logic   dst_valid;
        areg_t  dst;
        fmask_t flag_wr;
        tag_t   tag;
    } slot_upd_t;

    function automatic map_t reset_map();
        map_t m;
        for (int i = 0; i < ARCH_REGS; i++) m[i] = tag_t'(i);
        for (int g = 0; g < FLAG_GROUPS; g++) m[ARCH_REGS+g] = tag_t'(RESET_FLAG_TAG);
        return m;
    endfunction

    function automatic logic [SLOTS-1:0] slot_mask(slot_upd_t u);
        logic [SLOTS-1:0] m;
        m = '0;
        if (u.valid) begin
            if (u.dst_valid) m[u.dst] = 1'b1;
            for (int g = 0; g < FLAG_GROUPS; g++)
                if (u.flag_wr[g]) m[ARCH_REGS+g] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/rat_slot_file.sv
module rat_slot_file
    import rat_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  slot_upd_t upd,
    input  logic      load_en,
    input  map_t      load_val,
    output map_t      map_d,
    output map_t      map_q
);
    logic [SLOTS-1:0] wmask;

    always_comb begin
        wmask = slot_mask(upd);
        map_d = map_q;
        if (load_en) begin
            map_d = load_val;
        end else begin
            for (int s = 0; s < SLOTS; s++)
                if (wmask[s]) map_d[s] = upd.tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) map_q <= reset_map();
        else     map_q <= map_d;
    end
endmodule

// File: rtl/rat_free_pool.sv
module rat_free_pool
    import rat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  map_t spec_q,
    input  map_t cmt_q,
    input  logic alloc_en,
    input  logic retire_en,
    input  tag_t retire_tag,
    input  logic flush,
    output logic free_any,
    output tag_t free_tag
);
    pvec_t refd;
    pvec_t held_q;
    pvec_t avail;

    always_comb begin
        refd = '0;
        for (int s = 0; s < SLOTS; s++) begin
            refd[spec_q[s]] = 1'b1;
            refd[cmt_q[s]]  = 1'b1;
        end
        avail = ~refd & ~held_q;
    end

    always_comb begin
        free_any = 1'b0;
        free_tag = '0;
        for (int t = PHYS_REGS-1; t >= 0; t--) begin
            if (avail[t]) begin
                free_any = 1'b1;
                free_tag = tag_t'(t);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            held_q <= '0;
        end else begin
            if (retire_en) held_q[retire_tag] <= 1'b0;
            if (alloc_en)  held_q[free_tag]   <= 1'b1;
        end
    end

    AST_ALLOC_HELD: assert property (@(posedge clk) disable iff (rst)
        (alloc_en && !flush) |=> held_q[$past(free_tag)]) else $error("alloc not held"); // R8
endmodule

// File: rtl/flag_rename_table.sv
module flag_rename_table
    import rat_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ren_valid,
    input  logic [ARCH_W-1:0]             ren_src_a,
    input  logic [ARCH_W-1:0]             ren_src_b,
    input  logic                          ren_dst_valid,
    input  logic [ARCH_W-1:0]             ren_dst,
    input  logic [FLAG_GROUPS-1:0]        ren_flag_wr,
    output logic [TAG_W-1:0]              ren_tag_a,
    output logic [TAG_W-1:0]              ren_tag_b,
    output logic [FLAG_GROUPS*TAG_W-1:0]  ren_flag_tags,
    output logic                          ren_alloc,
    output logic [TAG_W-1:0]              ren_new_tag,
    output logic                          ren_stall,
    input  logic                          cmt_valid,
    input  logic                          cmt_dst_valid,
    input  logic [ARCH_W-1:0]             cmt_dst,
    input  logic [FLAG_GROUPS-1:0]        cmt_flag_wr,
    input  logic [TAG_W-1:0]              cmt_tag,
    input  logic                          flush
);
    map_t      spec_q, spec_d;
    map_t      cmt_q, cmt_d;
    slot_upd_t spec_upd, cmt_upd;
    logic      need_tag, free_any, retire_en;
    tag_t      free_tag;

    assign need_tag  = ren_dst_valid | (|ren_flag_wr);
    assign ren_alloc = ren_valid & need_tag & free_any & ~flush;
    assign ren_stall = ren_valid & need_tag & ~free_any & ~flush;
    assign ren_new_tag = free_tag;

    assign ren_tag_a = spec_q[ren_src_a];
    assign ren_tag_b = spec_q[ren_src_b];

    generate
        for (genvar g = 0; g < FLAG_GROUPS; g++) begin : g_flag_out
            assign ren_flag_tags[g*TAG_W +: TAG_W] = spec_q[ARCH_REGS+g];
        end
    endgenerate

    always_comb begin
        spec_upd.valid     = ren_alloc;
        spec_upd.dst_valid = ren_dst_valid;
        spec_upd.dst       = ren_dst;
        spec_upd.flag_wr   = ren_flag_wr;
        spec_upd.tag       = free_tag;
        cmt_upd.valid      = cmt_valid;
        cmt_upd.dst_valid  = cmt_dst_valid;
        cmt_upd.dst        = cmt_dst;
        cmt_upd.flag_wr    = cmt_flag_wr;
        cmt_upd.tag        = cmt_tag;
    end

    assign retire_en = cmt_valid & (cmt_dst_valid | (|cmt_flag_wr));

    rat_slot_file u_spec (
        .clk(clk), .rst(rst), .upd(spec_upd),
        .load_en(flush), .load_val(cmt_d),
        .map_d(spec_d), .map_q(spec_q)
    );

    rat_slot_file u_cmt (
        .clk(clk), .rst(rst), .upd(cmt_upd),
        .load_en(1'b0), .load_val(cmt_q),
        .map_d(cmt_d), .map_q(cmt_q)
    );

    rat_free_pool u_pool (
        .clk(clk), .rst(rst), .spec_q(spec_q), .cmt_q(cmt_q),
        .alloc_en(ren_alloc), .retire_en(retire_en), .retire_tag(cmt_tag),
        .flush(flush), .free_any(free_any), .free_tag(free_tag)
    );

    AST_DST_MAPPED: assert property (@(posedge clk) disable iff (rst)
        (ren_alloc && ren_dst_valid) |=> spec_q[$past(ren_dst)] == $past(ren_new_tag)) else $error("dst map"); // R3
    AST_CARRY_KEPT: assert property (@(posedge clk) disable iff (rst)
        (ren_valid && !ren_flag_wr[0] && !flush) |=> $stable(spec_q[ARCH_REGS])) else $error("carry moved"); // R4
    AST_STALL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (ren_stall && !flush) |=> $stable(spec_q)) else $error("map moved on stall"); // R7
    AST_STALL_EXCL: assert property (@(posedge clk) disable iff (rst)
        ren_stall |-> !ren_alloc) else $error("stall with alloc"); // R7
    AST_FLUSH_COPY: assert property (@(posedge clk) disable iff (rst)
        flush |=> spec_q == cmt_q) else $error("flush copy"); // R9
    AST_FLUSH_DISCARD: assert property (@(posedge clk) disable iff (rst)
        flush |-> !ren_alloc && !ren_stall) else $error("rename during flush"); // R11
endmodule

// File: tb/tb_flag_rename_table.sv
module tb_flag_rename_table;
    logic clk = 0, rst = 1;
    always #5 clk = ~clk;

    logic       ren_valid = 0, ren_dst_valid = 0;
    logic [2:0] ren_src_a = 0, ren_src_b = 0, ren_dst = 0;
    logic [1:0] ren_flag_wr = 0;
    logic [4:0] ren_tag_a, ren_tag_b, ren_new_tag;
    logic [9:0] ren_flag_tags;
    logic       ren_alloc, ren_stall;
    logic       cmt_valid = 0, cmt_dst_valid = 0;
    logic [2:0] cmt_dst = 0;
    logic [1:0] cmt_flag_wr = 0;
    logic [4:0] cmt_tag = 0;
    logic       flush = 0;

    flag_rename_table dut (.*);

    typedef struct {
        string req;
        int a, b, fc, fo, nt;
        bit alloc, stall;
    } exp_t;
    exp_t sb[$];

    typedef struct { int tag; bit dv; int d; int fw; } pend_t;
    pend_t order[$];

    int m_spec[10], m_cmt[10];
    bit m_held[32];
    int total = 0, bad = 0;
    bit done = 0;

    function automatic int pick_free();
        for (int t = 0; t < 32; t++) begin
            bit used = m_held[t];
            for (int s = 0; s < 10; s++)
                if (m_spec[s] == t || m_cmt[s] == t) used = 1;
            if (!used) return t;
        end
        return -1;
    endfunction

    task automatic ren(string req, int a, int b, bit dv, int d, int fw, bit fl = 0);
        exp_t e;
        int f;
        @(posedge clk); #1;
        ren_valid = 1; ren_src_a = 3'(a); ren_src_b = 3'(b);
        ren_dst_valid = dv; ren_dst = 3'(d); ren_flag_wr = 2'(fw); flush = fl;
        e.req = req; e.a = m_spec[a]; e.b = m_spec[b];
        e.fc = m_spec[8]; e.fo = m_spec[9];
        f = pick_free();
        e.alloc = !fl && (dv || fw != 0) && f >= 0;
        e.stall = !fl && (dv || fw != 0) && f < 0;
        e.nt = f;
        sb.push_back(e);
        if (fl) begin
            m_spec = m_cmt;
            foreach (m_held[t]) m_held[t] = 0;
            order.delete();
        end else if (e.alloc) begin
            pend_t p;
            if (dv) m_spec[d] = f;
            if (fw[0]) m_spec[8] = f;
            if (fw[1]) m_spec[9] = f;
            m_held[f] = 1;
            p.tag = f; p.dv = dv; p.d = d; p.fw = fw;
            order.push_back(p);
        end
    endtask

    task automatic idle();
        @(posedge clk); #1;
        ren_valid = 0; ren_dst_valid = 0; ren_flag_wr = 0; flush = 0;
        cmt_valid = 0; cmt_dst_valid = 0; cmt_flag_wr = 0;
    endtask

    task automatic commit_oldest();
        pend_t p;
        p = order.pop_front();
        @(posedge clk); #1;
        ren_valid = 0; flush = 0;
        cmt_valid = 1; cmt_dst_valid = p.dv; cmt_dst = 3'(p.d);
        cmt_flag_wr = 2'(p.fw); cmt_tag = 5'(p.tag);
        if (p.dv) m_cmt[p.d] = p.tag;
        if (p.fw[0]) m_cmt[8] = p.tag;
        if (p.fw[1]) m_cmt[9] = p.tag;
        m_held[p.tag] = 0;
        @(posedge clk); #1;
        cmt_valid = 0; cmt_dst_valid = 0; cmt_flag_wr = 0;
    endtask

    task automatic do_flush();
        @(posedge clk); #1;
        ren_valid = 0; cmt_valid = 0; flush = 1;
        m_spec = m_cmt;
        foreach (m_held[t]) m_held[t] = 0;
        order.delete();
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            bit ok;
            e = sb.pop_front();
            ok = ren_tag_a == 5'(e.a) && ren_tag_b == 5'(e.b)
              && ren_flag_tags[4:0] == 5'(e.fc) && ren_flag_tags[9:5] == 5'(e.fo)
              && ren_alloc == e.alloc && ren_stall == e.stall
              && (!e.alloc || ren_new_tag == 5'(e.nt));
            total++;
            if (!ok) begin
                bad++;
                $display("FAIL %s: got a=%0d b=%0d fc=%0d fo=%0d alloc=%0b nt=%0d stall=%0b exp a=%0d b=%0d fc=%0d fo=%0d alloc=%0b nt=%0d stall=%0b",
                    e.req, ren_tag_a, ren_tag_b, ren_flag_tags[4:0], ren_flag_tags[9:5],
                    ren_alloc, ren_new_tag, ren_stall,
                    e.a, e.b, e.fc, e.fo, e.alloc, e.nt, e.stall);
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hung expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_spec[i] = i; m_cmt[i] = i; end
        m_spec[8] = 8; m_spec[9] = 8; m_cmt[8] = 8; m_cmt[9] = 8;
        foreach (m_held[t]) m_held[t] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        ren("R1_reset_map", 0, 7, 0, 0, 0);
        ren("R6_no_alloc", 5, 6, 0, 0, 0);
        ren("R2_R5_dst_and_flags", 1, 2, 1, 3, 3);
        ren("R3_R4_carry_only", 3, 4, 0, 0, 1);
        ren("R4_split_providers", 3, 3, 0, 0, 0);
        ren("R4_other_only", 0, 1, 0, 0, 2);
        ren("R4_check_groups", 2, 3, 0, 0, 0);
        ren("R3_dst_only", 3, 3, 1, 3, 0);
        ren("R3_new_map", 3, 0, 0, 0, 0);
        commit_oldest();
        commit_oldest();
        ren("R11_flush_discard", 3, 3, 1, 5, 3, 1);
        ren("R9_R10_after_flush", 3, 5, 1, 6, 1);
        ren("R8_lowest_free", 6, 3, 1, 6, 0);
        for (int k = 0; k < 30; k++) ren("R7_R8_fill", 0, 6, 1, k % 8, k % 4);
        ren("R7_stall_hold", 0, 1, 1, 2, 0);
        ren("R7_map_unchanged", 2, 1, 0, 0, 0);
        repeat (5) commit_oldest();
        for (int k = 0; k < 4; k++) ren("R8_reuse", k, 7 - k, 1, k, 2);
        do_flush();
        ren("R9_restore", 0, 1, 0, 0, 0);
        ren("R10_pool_rebuilt", 2, 3, 1, 4, 1);
        idle();
        idle();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule